// File: doc/BRIEF.md
# Control Register and Standby Sequencer

This block sits in a serial bus protocol controller. It holds the host's one-byte control register and runs the power-mode sequencer around it. A host write can do three things. It can turn on slave reception, which sets a status flag that enables both addressed-slave and broadcast reception. It can issue a one-cycle internal soft-reset pulse. It can request or cancel standby.

A standby request is not honoured at once. The sequencer waits until the bus reports its idle (carrier-sense) condition. It then releases the bus drivers, gates the internal clock and raises the standby status flag. Stored state is kept throughout. Clearing the request starts a settling wait. This wait counts a parameterized number of pulses from a free-running reference tick, which stands in for the oscillator start-up time. When the count is complete, operation resumes where it stopped.

From the moment a request is pending until the block is fully awake again, host accesses are limited to control writes and status reads. Any other access is refused and reported with an error pulse.

Top module: `ctrl_standby_seq`

## Requirements
- R1: After reset, all of the following hold: the receive flag is 0, soft-reset is 0, the standby flag is 0, bus release is 0, the clock enable is 1, the error pulse is 0, and the status byte reads 0. The control register sits at address 0. In it, bit 0 requests standby, bit 1 is soft reset and bit 2 is receive enable. Bits 7..3 have no effect.
- R2: A control write with bit 2 set and bit 1 clear sets the receive flag on the next cycle. The status byte at address 1 shows the receive flag in bit 1 and the standby flag in bit 0.
- R3: A control write with bit 1 set gives exactly one cycle of soft-reset on the next cycle and clears the receive flag, even when bit 2 is also set. The standby-request bit still takes the value written.
- R4: After a write of bit 0 = 1, the standby flag rises on the third cycle after the write, but only if the bus is idle at that point. While the bus is busy the request stays pending and the flag stays 0.
- R5: While the standby flag is 1, bus release is 1 and the clock enable is 0.
- R6: After a write of bit 0 = 0 in standby, the flag stays 1 until SETTLE_TICKS reference ticks have been counted. Cycles without a tick do not count. The flag clears on the cycle after the last tick is sampled, and the receive flag keeps its value from before standby.
- R7: While a request is pending, and during standby or settling, only writes to address 0 and reads of address 1 are granted. Any other access gets a grant of 0 in the same cycle and an error pulse of one cycle on the next cycle. In normal run, every access is granted.
- R8: Writing bit 0 = 0 while entry is still pending cancels the entry. The block returns to run, and the standby flag does not rise even when the bus later becomes idle.
- R9: A soft reset written during standby still pulses and still clears the receive flag, but the standby flag stays 1.
- R10: Writing bits 1 and 0 together from run first resets, clearing the receive flag, and then enters standby once the bus is idle, on the third cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 8 | Write data |
| bus_idle | input | 1 | Bus is in the idle carrier-sense state |
| ref_tick | input | 1 | Free-running settle reference pulse |
| host_grant | output | 1 | Current access is permitted |
| access_error | output | 1 | One-cycle pulse after a refused access |
| status_rdata | output | 8 | Status byte (bit 0 standby, bit 1 receive) |
| slave_rx_en | output | 1 | Slave and broadcast reception enabled |
| soft_rst_pulse | output | 1 | One-cycle internal reset |
| bus_release | output | 1 | Bus drivers released to high impedance |
| clk_gate_en | output | 1 | Internal clock runs |
| standby_flag | output | 1 | Standby mode status |

## Verification
Three results appear one cycle after the write that causes them: the receive flag, the soft-reset pulse and the error pulse. The standby flag needs three cycles, because it passes through the request register, the waiting state and the standby state. Wake-up needs two cycles plus one per counted reference tick. Grant is combinational and is checked in the cycle the access is driven. Each stimulus task records the cycle in which it drives. It then queues each expected value with its due cycle, taken from those counts, and a monitor compares the outputs just after every rising edge. The monitor checks only the entries due in that cycle, so no output is sampled early or late.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_WAIT_IDLE = 2'd1,
    ST_STANDBY   = 2'd2,
    ST_WAKE      = 2'd3
  } seq_state_t;

  localparam int CTL_STBY_BIT  = 0;
  localparam int CTL_SRST_BIT  = 1;
  localparam int CTL_RXEN_BIT  = 2;
  localparam int STAT_STBY_BIT = 0;
  localparam int STAT_RXEN_BIT = 1;

  typedef struct packed {
    logic rx_en;
    logic soft_rst;
    logic stby_req;
  } ctl_cmd_t;

  function automatic ctl_cmd_t decode_ctl(input logic [7:0] d);
    ctl_cmd_t c;
    c.rx_en    = d[CTL_RXEN_BIT];
    c.soft_rst = d[CTL_SRST_BIT];
    c.stby_req = d[CTL_STBY_BIT];
    return c;
  endfunction

  function automatic logic state_blocks_host(input seq_state_t s);
    return s != ST_RUN;
  endfunction

  function automatic logic state_in_standby(input seq_state_t s);
    return (s == ST_STANDBY) || (s == ST_WAKE);
  endfunction

  function automatic logic access_permitted(input logic blocked, input logic is_write,
                                            input logic hit_ctrl, input logic hit_stat);
    return !blocked || (is_write && hit_ctrl) || (!is_write && hit_stat);
  endfunction

  function automatic logic settle_last(input int unsigned cnt, input int unsigned limit);
    return (limit == 0) || (cnt == limit - 1);
  endfunction

  function automatic logic [7:0] pack_status(input logic stby, input logic rx);
    logic [7:0] s;
    s = '0;
    s[STAT_STBY_BIT] = stby;
    s[STAT_RXEN_BIT] = rx;
    return s;
  endfunction

endpackage

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg
  import cs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic              ctrl_wr,
  output logic              stby_req,
  output logic              rx_en,
  output logic              srst_pulse
);

  ctl_cmd_t cmd;

  assign ctrl_wr = host_valid && host_write && (host_addr == CTRL_ADDR);
  assign cmd     = decode_ctl(host_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_req   <= 1'b0;
      rx_en      <= 1'b0;
      srst_pulse <= 1'b0;
    end else begin
      srst_pulse <= ctrl_wr && cmd.soft_rst;
      if (ctrl_wr) begin
        stby_req <= cmd.stby_req;
        if (cmd.soft_rst)   rx_en <= 1'b0;
        else if (cmd.rx_en) rx_en <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cs_settle_timer.sv
module cs_settle_timer
  import cs_pkg::*;
#(
  parameter int SETTLE_TICKS = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ref_tick,
  output logic settle_done
);

  localparam int CNT_W = (SETTLE_TICKS < 2) ? 1 : $clog2(SETTLE_TICKS + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!active)  cnt <= '0;
    else if (ref_tick) cnt <= cnt + CNT_W'(1);
  end

  assign settle_done = active && ref_tick && settle_last(32'(cnt), SETTLE_TICKS);

endmodule

// File: rtl/cs_standby_fsm.sv
module cs_standby_fsm
  import cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req,
  input  logic       bus_idle,
  input  logic       settle_done,
  output seq_state_t state,
  output logic       enter_evt,
  output logic       wake_evt,
  output logic       resume_evt
);

  seq_state_t nxt;

  always_comb begin
    nxt        = state;
    enter_evt  = 1'b0;
    wake_evt   = 1'b0;
    resume_evt = 1'b0;
    unique case (state)
      ST_RUN: if (stby_req) nxt = ST_WAIT_IDLE;
      ST_WAIT_IDLE: begin
        if (!stby_req) nxt = ST_RUN;
        else if (bus_idle) begin
          nxt       = ST_STANDBY;
          enter_evt = 1'b1;
        end
      end
      ST_STANDBY: if (!stby_req) begin
        nxt      = ST_WAKE;
        wake_evt = 1'b1;
      end
      ST_WAKE: if (settle_done) begin
        nxt        = ST_RUN;
        resume_evt = 1'b1;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

endmodule

// File: rtl/cs_access_guard.sv
module cs_access_guard
  import cs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blocked,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              host_grant,
  output logic              refused,
  output logic              access_error
);

  logic hit_ctrl, hit_stat;

  assign hit_ctrl   = host_addr == CTRL_ADDR;
  assign hit_stat   = host_addr == STAT_ADDR;
  assign host_grant = host_valid && access_permitted(blocked, host_write, hit_ctrl, hit_stat);
  assign refused    = host_valid && !host_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) access_error <= 1'b0;
    else        access_error <= refused;
  end

endmodule

// File: rtl/ctrl_standby_seq.sv
module ctrl_standby_seq
  import cs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 1,
  parameter int SETTLE_TICKS = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              bus_idle,
  input  logic              ref_tick,
  output logic              host_grant,
  output logic              access_error,
  output logic [7:0]        status_rdata,
  output logic              slave_rx_en,
  output logic              soft_rst_pulse,
  output logic              bus_release,
  output logic              clk_gate_en,
  output logic              standby_flag
);

  logic       ctrl_wr, stby_req, rx_en, settle_done, refused;
  logic       enter_evt, wake_evt, resume_evt;
  seq_state_t state;

  cs_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .ctrl_wr(ctrl_wr),
    .stby_req(stby_req), .rx_en(rx_en), .srst_pulse(soft_rst_pulse)
  );

  cs_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(state == ST_WAKE), .ref_tick(ref_tick),
    .settle_done(settle_done)
  );

  cs_standby_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .bus_idle(bus_idle),
    .settle_done(settle_done), .state(state), .enter_evt(enter_evt),
    .wake_evt(wake_evt), .resume_evt(resume_evt)
  );

  cs_access_guard #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_guard (
    .clk(clk), .rst_n(rst_n), .blocked(state_blocks_host(state)),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .host_grant(host_grant), .refused(refused), .access_error(access_error)
  );

  assign standby_flag = state_in_standby(state);
  assign bus_release  = standby_flag;
  assign clk_gate_en  = !standby_flag;
  assign slave_rx_en  = rx_en;
  assign status_rdata = pack_status(standby_flag, rx_en);

endmodule

// File: rtl/cs_checker.sv
module cs_checker
  import cs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_write,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic              bus_idle,
  input logic              ref_tick,
  input logic              host_grant,
  input logic              access_error,
  input logic              slave_rx_en,
  input logic              soft_rst_pulse,
  input logic              bus_release,
  input logic              clk_gate_en,
  input logic              standby_flag,
  input seq_state_t        state,
  input logic              enter_evt,
  input logic              resume_evt
);

  logic cw;
  assign cw = host_valid && host_write && (host_addr == CTRL_ADDR);

  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && host_wdata[CTL_RXEN_BIT] && !host_wdata[CTL_SRST_BIT]) |=> slave_rx_en);
  // R3
  srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && host_wdata[CTL_SRST_BIT]) |=> (soft_rst_pulse && !slave_rx_en));
  // R3
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cw && host_wdata[CTL_SRST_BIT]) |=> !soft_rst_pulse);
  // R4
  entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_flag) |-> ($past(bus_idle) && $past(enter_evt)));
  // R5
  stby_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_flag |-> (bus_release && !clk_gate_en));
  // R6
  wake_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby_flag) |-> ($past(ref_tick) && $past(resume_evt)));
  // R7
  refuse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_grant) |=> access_error);
  // R7
  run_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && host_valid) |-> host_grant);
  // R9
  srst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_pulse && $past(state) == ST_STANDBY) |-> standby_flag);

endmodule

bind ctrl_standby_seq cs_checker #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
  .host_addr(host_addr), .host_wdata(host_wdata), .bus_idle(bus_idle),
  .ref_tick(ref_tick), .host_grant(host_grant), .access_error(access_error),
  .slave_rx_en(slave_rx_en), .soft_rst_pulse(soft_rst_pulse),
  .bus_release(bus_release), .clk_gate_en(clk_gate_en),
  .standby_flag(standby_flag), .state(state), .enter_evt(enter_evt),
  .resume_evt(resume_evt)
);

// File: tb/ctrl_standby_seq_bench.sv
module ctrl_standby_seq_bench;

  localparam int S = 4;
  localparam int SIG_RX = 0, SIG_SRST = 1, SIG_STBY = 2, SIG_REL = 3,
                 SIG_GATE = 4, SIG_ERR = 5, SIG_STAT = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0, host_write = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       bus_idle = 1'b0, ref_tick = 1'b1;
  logic       host_grant, access_error, slave_rx_en, soft_rst_pulse;
  logic       bus_release, clk_gate_en, standby_flag;
  logic [7:0] status_rdata;

  int tests = 0, fails = 0, cyc = 0, base = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    int    sig;
    int    val;
    string req;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  ctrl_standby_seq #(.ADDR_W(2), .SETTLE_TICKS(S)) u_ctrl_standby_seq (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .bus_idle(bus_idle),
    .ref_tick(ref_tick), .host_grant(host_grant), .access_error(access_error),
    .status_rdata(status_rdata), .slave_rx_en(slave_rx_en),
    .soft_rst_pulse(soft_rst_pulse), .bus_release(bus_release),
    .clk_gate_en(clk_gate_en), .standby_flag(standby_flag)
  );

  function automatic int sample(int sig);
    case (sig)
      SIG_RX:   return int'(slave_rx_en);
      SIG_SRST: return int'(soft_rst_pulse);
      SIG_STBY: return int'(standby_flag);
      SIG_REL:  return int'(bus_release);
      SIG_GATE: return int'(clk_gate_en);
      SIG_ERR:  return int'(access_error);
      default:  return int'(status_rdata);
    endcase
  endfunction

  task automatic check(int act, int exp, string req, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #3;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        check(sample(sb[i].sig), sb[i].val, sb[i].req, $sformatf("sig%0d", sb[i].sig));
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(int dly, int sig, int val, string req);
    exp_t e;
    e.due = base + dly; e.sig = sig; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic drive(logic wr, logic [1:0] addr, logic [7:0] d, int grant_exp, string req);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = addr; host_wdata = d;
    base = cyc;
    #1 check(int'(host_grant), grant_exp, req, "grant");
  endtask

  task automatic release_bus();
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0; host_wdata = '0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(sample(SIG_RX), 0, "R1", "rx");
    check(sample(SIG_SRST), 0, "R1", "srst");
    check(sample(SIG_STBY), 0, "R1", "stby");
    check(sample(SIG_REL), 0, "R1", "release");
    check(sample(SIG_GATE), 1, "R1", "clk_en");
    check(sample(SIG_ERR), 0, "R1", "err");
    check(sample(SIG_STAT), 0, "R1", "status");

    // R2 receive enable
    drive(1, 2'd0, 8'h04, 1, "R2");
    expect_at(1, SIG_RX, 1, "R2"); expect_at(1, SIG_STAT, 2, "R2");
    release_bus(); wait_cyc(2);

    // R1 bits 7..3 ignored
    drive(1, 2'd0, 8'hF8, 1, "R1");
    expect_at(1, SIG_RX, 1, "R1"); expect_at(1, SIG_SRST, 0, "R1");
    expect_at(3, SIG_STBY, 0, "R1"); expect_at(3, SIG_STAT, 2, "R1");
    release_bus(); wait_cyc(4);

    // R3 soft reset wins over receive enable
    drive(1, 2'd0, 8'h06, 1, "R3");
    expect_at(1, SIG_SRST, 1, "R3"); expect_at(2, SIG_SRST, 0, "R3");
    expect_at(1, SIG_RX, 0, "R3");
    release_bus(); wait_cyc(3);

    // R4 pending while bus busy; R7 refused access; R8 cancel
    bus_idle = 1'b0;
    drive(1, 2'd0, 8'h01, 1, "R4");
    expect_at(3, SIG_STBY, 0, "R4"); expect_at(6, SIG_STBY, 0, "R4");
    release_bus(); wait_cyc(2);
    drive(1, 2'd2, 8'h55, 0, "R7");
    expect_at(1, SIG_ERR, 1, "R7"); expect_at(2, SIG_ERR, 0, "R7");
    release_bus(); wait_cyc(3);
    drive(1, 2'd0, 8'h00, 1, "R8");
    expect_at(3, SIG_STBY, 0, "R8");
    release_bus(); wait_cyc(3);
    drive(1, 2'd2, 8'h55, 1, "R8");
    expect_at(1, SIG_ERR, 0, "R8");
    release_bus();
    bus_idle = 1'b1;
    wait_cyc(4);
    #1 check(sample(SIG_STBY), 0, "R8", "no entry after cancel");

    // R4/R5 entry with receive enabled
    drive(1, 2'd0, 8'h04, 1, "R2");
    release_bus();
    drive(1, 2'd0, 8'h01, 1, "R4");
    expect_at(2, SIG_STBY, 0, "R4"); expect_at(3, SIG_STBY, 1, "R4");
    expect_at(3, SIG_REL, 1, "R5"); expect_at(3, SIG_GATE, 0, "R5");
    expect_at(3, SIG_STAT, 3, "R5");
    release_bus(); wait_cyc(4);

    // R7 in standby
    drive(0, 2'd1, 8'h00, 1, "R7");
    expect_at(1, SIG_ERR, 0, "R7");
    release_bus();
    drive(0, 2'd3, 8'h00, 0, "R7");
    expect_at(1, SIG_ERR, 1, "R7");
    release_bus();
    drive(1, 2'd2, 8'h11, 0, "R7");
    expect_at(1, SIG_ERR, 1, "R7");
    release_bus(); wait_cyc(2);

    // R6 settle without ticks, then with ticks; receive flag kept
    ref_tick = 1'b0;
    drive(1, 2'd0, 8'h00, 1, "R6");
    release_bus(); wait_cyc(8);
    #1 check(sample(SIG_STBY), 1, "R6", "held without ticks");
    @(negedge clk);
    ref_tick = 1'b1;
    base = cyc;
    expect_at(S - 1, SIG_STBY, 1, "R6"); expect_at(S, SIG_STBY, 0, "R6");
    expect_at(S, SIG_GATE, 1, "R6"); expect_at(S, SIG_REL, 0, "R6");
    expect_at(S, SIG_RX, 1, "R6");
    wait_cyc(S + 2);

    // R10 reset plus standby together
    drive(1, 2'd0, 8'h03, 1, "R10");
    expect_at(1, SIG_SRST, 1, "R10"); expect_at(1, SIG_RX, 0, "R10");
    expect_at(2, SIG_STBY, 0, "R10"); expect_at(3, SIG_STBY, 1, "R10");
    release_bus(); wait_cyc(4);

    // R9 soft reset during standby
    drive(1, 2'd0, 8'h03, 1, "R9");
    expect_at(1, SIG_SRST, 1, "R9"); expect_at(1, SIG_STBY, 1, "R9");
    expect_at(2, SIG_SRST, 0, "R9"); expect_at(3, SIG_STBY, 1, "R9");
    release_bus(); wait_cyc(3);

    // R6 exit with continuous ticks
    drive(1, 2'd0, 8'h00, 1, "R6");
    expect_at(S + 1, SIG_STBY, 1, "R6"); expect_at(S + 2, SIG_STBY, 0, "R6");
    release_bus();

    for (int k = 0; k < 50 && sb.size() != 0; k++) @(negedge clk);
    if (sb.size() != 0) check(sb.size(), 0, "R1", "undrained expectations");
    summary();
  end

endmodule